// File: doc/BRIEF.md
# Change-on-Sleep Wake Detector

This block notices that a watched input has moved while the device is in its low-power state. When that happens it asks the rest of the chip to wake, and it records which input caused the wake. There are two channels. One watches the single-bit comparator result. The other watches a group of three general-purpose input pins. The block works on digital levels that have already been synchronised to `clk`.

A channel does not compare its input against the previous clock sample. It compares it against a reference copy that is taken when software reads that input, which is signalled by a one-cycle read strobe. If no read has happened since reset, the reference is taken in the first cycle the sleep input is high. A mismatch counts only when the device is asleep and the channel's active-low enable is 0. The result is a single-cycle wake request and a sticky per-channel flag. The flags survive the restart that the wake request causes. Only the block's own reset clears them.

Top module: `wake_detect_top`

## Requirements
- R1: The comparator channel (`cmp_i`) can raise a wake only while `cmp_wake_en_n_i` is 0. With it at 1, a comparator mismatch during sleep leaves `cmp_flag_o` and `wake_req_o` unchanged.
- R2: The pin channel can raise a wake only while `pin_wake_en_n_i` is 0. With it at 1, a pin mismatch during sleep leaves `pin_flag_o` and `wake_req_o` unchanged.
- R3: A high read strobe (`cmp_rd_i` or `pin_rd_i`) at a clock edge copies that channel's live input into its reference. During sleep the live input is compared against this copy, not against the previous sample. An input that changed after the last read therefore wakes the device in the first sleep cycle.
- R4: The pin channel watches a 3-bit bus `pin_i` and ignores no bit of it. A change on any one of bits 0, 1 or 2 relative to the reference is a pin mismatch.
- R5: While `sleep_i` is 0, input changes set no flag and raise no wake request.
- R6: If a channel has had no read since reset, its reference is loaded from its input in the first cycle `sleep_i` is high. No wake is judged in that cycle.
- R7: A mismatch in a cycle where `sleep_i` is 1 (with the enable at 0 and a valid reference) drives `wake_req_o` and the channel's flag high after that same clock edge. `wake_req_o` is high for exactly one cycle.
- R8: Each flag is sticky and goes low only on `rst`. If both channels mismatch in the same cycle, both flags are set.
- R9: A synchronous active-high `rst` clears both flags, both references, the reference-valid state and `wake_req_o`.
- R10: Only one wake request is issued per sleep period. After `sleep_i` has been 0 for at least one cycle and then goes high again, a persisting or new mismatch raises a fresh request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high full reset; clears flags |
| sleep_i | input | 1 | High while the device is in its low-power state |
| cmp_i | input | 1 | Synchronised comparator result |
| cmp_rd_i | input | 1 | One-cycle strobe: software read of the comparator result |
| cmp_wake_en_n_i | input | 1 | Active-low comparator wake enable |
| pin_i | input | PIN_W (3) | Synchronised levels of the watched pins |
| pin_rd_i | input | 1 | One-cycle strobe: software access to the pin port |
| pin_wake_en_n_i | input | 1 | Active-low pin wake enable |
| wake_req_o | output | 1 | Single-cycle wake / restart request |
| cmp_flag_o | output | 1 | Sticky: the comparator caused a wake |
| pin_flag_o | output | 1 | Sticky: the pins caused a wake |

## Verification
Some properties are checked by the assertions on every cycle. A high enable freezes its flag. No request follows an awake cycle. A flag only rises after a sleeping cycle and never falls without reset. The request never lasts two cycles and always comes with a flag set. Other behaviour can only be shown by the bench's scenarios. These cover reference capture on a read and the fallback capture on sleep entry. They also cover the fact that the comparison uses the latched copy rather than the last sample, that each pin bit counts, and that re-arming works across sleep periods. A cycle-level reference model compares all three outputs every cycle under seeded random stimulus.

// File: rtl/wake_pkg.sv
package wake_pkg;
  parameter int unsigned PIN_GROUP_W = 3;

  typedef struct packed {
    logic hit;
    logic flag;
  } chan_stat_t;
endpackage

// File: rtl/wake_chan.sv
module wake_chan
  import wake_pkg::*;
#(
  parameter int unsigned W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] live_i,
  input  logic         rd_i,
  input  logic         en_n_i,
  input  logic         sleep_i,
  input  logic         sleep_entry_i,
  output chan_stat_t   stat_o
);
  logic [W-1:0] ref_q;
  logic         valid_q;
  logic         flag_q;
  logic         hit;

  // mismatch against the latched copy, gated by sleep and the active-low enable
  assign hit = sleep_i && !en_n_i && valid_q && (live_i != ref_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_q   <= '0;
      valid_q <= 1'b0;
      flag_q  <= 1'b0;
    end else begin
      if (rd_i || (sleep_entry_i && !valid_q)) begin
        ref_q   <= live_i;
        valid_q <= 1'b1;
      end
      if (hit) flag_q <= 1'b1;
    end
  end

  assign stat_o.hit  = hit;
  assign stat_o.flag = flag_q;

  AST_EN_FREEZES_FLAG: assert property (@(posedge clk) disable iff (rst)
    en_n_i |=> $stable(flag_q)); // R1
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    flag_q |=> flag_q); // R8
  AST_FLAG_ONLY_ASLEEP: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_q) |-> $past(sleep_i)); // R5
endmodule

// File: rtl/wake_pulse.sv
module wake_pulse (
  input  logic clk,
  input  logic rst,
  input  logic sleep_i,
  input  logic hit_any_i,
  output logic req_o
);
  logic fired_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_o   <= 1'b0;
      fired_q <= 1'b0;
    end else begin
      req_o <= hit_any_i && !fired_q;
      if (!sleep_i)       fired_q <= 1'b0;
      else if (hit_any_i) fired_q <= 1'b1;
    end
  end

  AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    req_o |=> !req_o); // R7
  AST_AWAKE_NO_REQ: assert property (@(posedge clk) disable iff (rst)
    !sleep_i |=> !req_o); // R5
endmodule

// File: rtl/wake_detect_top.sv
module wake_detect_top
  import wake_pkg::*;
#(
  parameter int unsigned PIN_W = PIN_GROUP_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sleep_i,
  input  logic             cmp_i,
  input  logic             cmp_rd_i,
  input  logic             cmp_wake_en_n_i,
  input  logic [PIN_W-1:0] pin_i,
  input  logic             pin_rd_i,
  input  logic             pin_wake_en_n_i,
  output logic             wake_req_o,
  output logic             cmp_flag_o,
  output logic             pin_flag_o
);
  logic       sleep_q;
  logic       sleep_entry;
  chan_stat_t cmp_stat;
  chan_stat_t pin_stat;

  always_ff @(posedge clk) begin
    if (rst) sleep_q <= 1'b0;
    else     sleep_q <= sleep_i;
  end

  assign sleep_entry = sleep_i && !sleep_q;

  wake_chan #(.W(1)) u_cmp (
    .clk           (clk),
    .rst           (rst),
    .live_i        (cmp_i),
    .rd_i          (cmp_rd_i),
    .en_n_i        (cmp_wake_en_n_i),
    .sleep_i       (sleep_i),
    .sleep_entry_i (sleep_entry),
    .stat_o        (cmp_stat)
  );

  wake_chan #(.W(PIN_W)) u_pin (
    .clk           (clk),
    .rst           (rst),
    .live_i        (pin_i),
    .rd_i          (pin_rd_i),
    .en_n_i        (pin_wake_en_n_i),
    .sleep_i       (sleep_i),
    .sleep_entry_i (sleep_entry),
    .stat_o        (pin_stat)
  );

  wake_pulse u_pulse (
    .clk       (clk),
    .rst       (rst),
    .sleep_i   (sleep_i),
    .hit_any_i (cmp_stat.hit || pin_stat.hit),
    .req_o     (wake_req_o)
  );

  assign cmp_flag_o = cmp_stat.flag;
  assign pin_flag_o = pin_stat.flag;

  AST_REQ_WITH_FLAG: assert property (@(posedge clk) disable iff (rst)
    wake_req_o |-> (cmp_flag_o || pin_flag_o)); // R7
  AST_PIN_EN_FREEZES: assert property (@(posedge clk) disable iff (rst)
    pin_wake_en_n_i |=> $stable(pin_flag_o)); // R2
endmodule

// File: tb/tb_wake_detect_top.sv
module tb_wake_detect_top;
  localparam int PW = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sleep_i = 1'b0;
  logic cmp_i = 1'b0, cmp_rd_i = 1'b0, cmp_en_n = 1'b0;
  logic [PW-1:0] pin_i = '0;
  logic pin_rd_i = 1'b0, pin_en_n = 1'b0;
  logic wake_req_o, cmp_flag_o, pin_flag_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  string tag = "R9";

  // reference model state
  logic m_cref, m_cval, m_cflag, m_pval, m_pflag, m_fired, m_req, m_sq;
  logic [PW-1:0] m_pref;

  always #2 clk = ~clk;

  wake_detect_top #(.PIN_W(PW)) dut (
    .clk(clk), .rst(rst), .sleep_i(sleep_i),
    .cmp_i(cmp_i), .cmp_rd_i(cmp_rd_i), .cmp_wake_en_n_i(cmp_en_n),
    .pin_i(pin_i), .pin_rd_i(pin_rd_i), .pin_wake_en_n_i(pin_en_n),
    .wake_req_o(wake_req_o), .cmp_flag_o(cmp_flag_o), .pin_flag_o(pin_flag_o)
  );

  function automatic logic chan_hit(logic sl, logic en_n, logic val, logic diff);
    return sl && !en_n && val && diff;
  endfunction

  task automatic model_step();
    logic entry, ch, ph;
    entry = sleep_i && !m_sq;
    if (rst) begin
      m_cref = 0; m_cval = 0; m_cflag = 0; m_pref = '0; m_pval = 0;
      m_pflag = 0; m_fired = 0; m_req = 0; m_sq = 0;
    end else begin
      ch = chan_hit(sleep_i, cmp_en_n, m_cval, cmp_i != m_cref);
      ph = chan_hit(sleep_i, pin_en_n, m_pval, pin_i != m_pref);
      if (cmp_rd_i || (entry && !m_cval)) begin m_cref = cmp_i; m_cval = 1; end
      if (pin_rd_i || (entry && !m_pval)) begin m_pref = pin_i; m_pval = 1; end
      if (ch) m_cflag = 1;
      if (ph) m_pflag = 1;
      m_req = (ch || ph) && !m_fired;
      if (!sleep_i) m_fired = 0; else if (ch || ph) m_fired = 1;
      m_sq = sleep_i;
    end
  endtask

  task automatic check(string t, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", t, what, act, exp, $time);
    end
  endtask

  task automatic tick();
    model_step();
    @(posedge clk);
    #1;
    check(tag, "wake_req_o", wake_req_o, m_req);
    check(tag, "cmp_flag_o", cmp_flag_o, m_cflag);
    check(tag, "pin_flag_o", pin_flag_o, m_pflag);
  endtask

  task automatic do_reset();
    rst = 1; sleep_i = 0; cmp_rd_i = 0; pin_rd_i = 0;
    tick();
    rst = 0;
  endtask

  task automatic read_both();
    cmp_rd_i = 1; pin_rd_i = 1; tick();
    cmp_rd_i = 0; pin_rd_i = 0;
  endtask

  initial begin
    void'($urandom(32'd20240607));

    tag = "R9";
    do_reset();
    check("R9", "reset wake_req_o", wake_req_o, 1'b0);
    check("R9", "reset cmp_flag_o", cmp_flag_o, 1'b0);

    // awake toggling is ignored
    tag = "R5";
    for (int i = 0; i < 6; i++) begin
      cmp_i = ~cmp_i; pin_i = pin_i + 3'd1; tick();
    end
    check("R5", "awake cmp_flag_o", cmp_flag_o, 1'b0);
    check("R5", "awake pin_flag_o", pin_flag_o, 1'b0);

    // no read since reset: reference taken at sleep entry
    tag = "R6";
    do_reset();
    cmp_i = 1; pin_i = 3'b101; sleep_i = 1;
    tick(); tick(); tick();
    check("R6", "steady after entry wake_req_o", wake_req_o, 1'b0);
    cmp_i = 0; tick();
    check("R6", "change after entry wake_req_o", wake_req_o, 1'b1);
    check("R6", "change after entry cmp_flag_o", cmp_flag_o, 1'b1);
    tag = "R7";
    tick();
    check("R7", "pulse is one cycle", wake_req_o, 1'b0);
    sleep_i = 0; tick();

    // enable high blocks the comparator channel
    tag = "R1";
    do_reset();
    cmp_en_n = 1; cmp_i = 0; read_both();
    sleep_i = 1; tick(); cmp_i = 1; tick(); tick();
    check("R1", "disabled cmp_flag_o", cmp_flag_o, 1'b0);
    check("R1", "disabled wake_req_o", wake_req_o, 1'b0);
    sleep_i = 0; cmp_en_n = 0; tick();

    // enable high blocks the pin channel
    tag = "R2";
    pin_en_n = 1; pin_i = 3'b000; cmp_i = 0; read_both();
    sleep_i = 1; tick(); pin_i = 3'b111; tick(); tick();
    check("R2", "disabled pin_flag_o", pin_flag_o, 1'b0);
    sleep_i = 0; pin_en_n = 0; pin_i = 3'b000; tick();

    // change after the read but before sleep wakes in first sleep cycle
    tag = "R3";
    do_reset();
    cmp_i = 0; pin_i = 3'b000; read_both();
    cmp_i = 1; tick(); tick();
    sleep_i = 1; tick();
    check("R3", "stale reference wake_req_o", wake_req_o, 1'b1);
    check("R3", "stale reference cmp_flag_o", cmp_flag_o, 1'b1);
    sleep_i = 0; tick();

    // each pin bit alone counts; pulse per sleep period
    tag = "R4";
    do_reset();
    for (int b = 0; b < PW; b++) begin
      pin_i = '0; cmp_i = 0; read_both();
      sleep_i = 1; tick();
      pin_i[b] = 1'b1; tick();
      check("R4", "single bit change wake_req_o", wake_req_o, 1'b1);
      sleep_i = 0; tick();
    end
    check("R4", "pin_flag_o after bit changes", pin_flag_o, 1'b1);
    check("R8", "cmp_flag_o untouched by pins", cmp_flag_o, 1'b0);

    // re-arm: persisting mismatch gives a new pulse on next sleep
    tag = "R10";
    sleep_i = 1; tick();
    check("R10", "re-armed wake_req_o", wake_req_o, 1'b1);
    tick();
    check("R10", "one request per period", wake_req_o, 1'b0);
    sleep_i = 0; tick();

    // both channels in the same cycle; flags persist
    tag = "R8";
    do_reset();
    cmp_i = 0; pin_i = 3'b010; read_both();
    sleep_i = 1; tick();
    cmp_i = 1; pin_i = 3'b011; tick();
    check("R8", "both cmp_flag_o", cmp_flag_o, 1'b1);
    check("R8", "both pin_flag_o", pin_flag_o, 1'b1);
    sleep_i = 0; read_both(); tick();
    check("R8", "flag sticks when awake", cmp_flag_o, 1'b1);
    tag = "R9";
    do_reset();
    check("R9", "reset clears pin_flag_o", pin_flag_o, 1'b0);

    // seeded random phase, model compared every cycle
    tag = "R8";
    for (int n = 0; n < 3000; n++) begin
      int r;
      r = $urandom_range(0, 99);
      rst      = (r == 0);
      if ($urandom_range(0, 15) == 0) sleep_i = ~sleep_i;
      if ($urandom_range(0, 5) == 0) cmp_i = ~cmp_i;
      if ($urandom_range(0, 5) == 0) pin_i[$urandom_range(0, PW-1)] ^= 1'b1;
      cmp_rd_i = !sleep_i && ($urandom_range(0, 7) == 0);
      pin_rd_i = !sleep_i && ($urandom_range(0, 7) == 0);
      if ($urandom_range(0, 40) == 0) cmp_en_n = ~cmp_en_n;
      if ($urandom_range(0, 40) == 0) pin_en_n = ~pin_en_n;
      tick();
    end

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule